// File: doc/BRIEF.md
# VMEbus Slave Page Map and Address Translator

This block watches the address phase of incoming VMEbus slave cycles and decides whether each one lands on a locally mapped 4MB page. Two page tables are held on chip, one consulted for extended (32-bit) address cycles and one for standard (24-bit) address cycles. The address-modifier code of the cycle picks the table. The upper ten address bits index it. Each entry says whether the page is unmapped, reached as a 32-bit target, or reached as a 24-bit target.

On a hit, the block forms the local bus address and raises a request towards the local bus arbiter. A 32-bit target passes the VMEbus address through unchanged. A 24-bit target takes its top eight bits from an extended-address input. A hit whose translated address falls inside the board's own VMEbus master window does not raise a request. It raises a bus-error indication instead. Software fills the tables through a write port and checks them through a registered read-back port. A slave-enable input gates all decoding.

Top module: `vme_slave_page_map`

## Requirements
- R1: After reset, `arb_req` and `bus_err` are low, `local_addr` is zero, and every entry of both tables reads back as code 00.
- R2: A write with `map_wr_en` high stores `map_wr_code` at `map_wr_idx` of the table chosen by `map_wr_sel` (0 = 32-bit table, 1 = 24-bit table). `map_rd_code` shows the entry selected by `map_rd_sel`/`map_rd_idx` one clock after they are presented.
- R3: The captured AM[5:4] picks the table: 00 picks the 32-bit table and 11 picks the 24-bit table. The values 01 and 10 never match. A cycle with AM[3] = 0 never matches.
- R4: Entry code 01 (32-bit target) gives `local_addr` equal to the captured 32-bit VMEbus address.
- R5: Entry code 10 (24-bit target) gives `local_addr` = {`ext_addr`, captured address bits 23..0}.
- R6: Entry codes 00 (unmapped) and 11 (reserved) never raise `arb_req` or `bus_err`.
- R7: When the 24-bit table holds the same code at all indices that share the same low two bits, a 24-bit cycle raises the same output and `local_addr` whatever address bits 31..24 carry.
- R8: While `slave_en` is low at the decision edge, no cycle raises `arb_req` or `bus_err`.
- R9: The address and modifiers are captured at the first clock edge that samples `vme_as_n` low after it was high. The outcome appears at the next edge. It is held until an edge samples `arb_ack` high or `vme_as_n` high. An acknowledge that arrives at the decision edge suppresses the outcome.
- R10: A hit whose translated address satisfies (`local_addr` & `mst_mask`) == `mst_base` raises `bus_err` and not `arb_req`. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vme_as_n | input | 1 | VMEbus address strobe, active low |
| vme_addr | input | 32 | VMEbus address |
| vme_am | input | 6 | VMEbus address modifier |
| slave_en | input | 1 | Slave decoding enable |
| ext_addr | input | 8 | Top address bits used for 24-bit targets |
| mst_base | input | 32 | Master window base |
| mst_mask | input | 32 | Master window compare mask |
| map_wr_en | input | 1 | Table write strobe |
| map_wr_sel | input | 1 | Table written: 0 = 32-bit, 1 = 24-bit |
| map_wr_idx | input | 10 | Page index written |
| map_wr_code | input | 2 | Entry code written |
| map_rd_sel | input | 1 | Table read back |
| map_rd_idx | input | 10 | Page index read back |
| map_rd_code | output | 2 | Entry code read back, one clock later |
| arb_ack | input | 1 | Acknowledge from the local arbiter |
| arb_req | output | 1 | Request to the local arbiter |
| bus_err | output | 1 | Bus error for the current VMEbus cycle |
| local_addr | output | 32 | Translated local bus address |

## Verification
The decoder is driven with cycles whose modifier codes cover the 32-bit and 24-bit spaces, the two unused AM[5:4] values and AM[3] clear. This separates table selection from qualification. Pages are loaded with each of the four entry codes, which separates pass-through from extended-address translation and shows that the reserved and unmapped codes are treated alike. The same 24-bit page is reached with different upper address bits over a replicated table, which shows that only bits 23..22 decide the result. Cycles into the master window, with `slave_en` cleared, and ended by acknowledge, by strobe release, or by an acknowledge at the decision edge show the error path, the gating and the hold rule apart.

// File: rtl/vpx_pkg.sv
// Shared definitions for the VMEbus slave page map.
// Assumes AM[5:4] = 00 marks extended and 11 marks standard address cycles.
package vpx_pkg;

    typedef enum logic [1:0] {
        PG_NONE = 2'b00,
        PG_A32  = 2'b01,
        PG_A24  = 2'b10,
        PG_RSVD = 2'b11
    } page_code_e;

    localparam logic [1:0] AM_SPACE_EXT = 2'b00;
    localparam logic [1:0] AM_SPACE_STD = 2'b11;

    // True when a stored code describes a usable target page
    function automatic logic code_is_target(input logic [1:0] c);
        return (c == PG_A32) || (c == PG_A24);
    endfunction

endpackage

// File: rtl/vpx_map_table.sv
// One page table: synchronous write, two combinational read ports
// (lookup and software read-back). All entries clear to unmapped on reset.
// Assumes the caller registers the read-back data.
module vpx_map_table #(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [1:0]        wr_code,
    input  logic [PAGE_W-1:0] lk_idx,
    output logic [1:0]        lk_code,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [1:0]        rd_code
);
    localparam int NUM_PAGES = 1 << PAGE_W;

    logic [1:0] mem [NUM_PAGES];

    // Entry storage: clear on reset, update on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAGES; i++) mem[i] <= 2'b00;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_code;
        end
    end

    // Read ports
    always_comb begin
        lk_code = mem[lk_idx];
        rd_code = mem[rd_idx];
    end
endmodule

// File: rtl/vpx_strobe_capture.sv
// Captures address and modifier on the clock edge that first sees the
// strobe low, and flags a decision pending for the following edge.
// Assumes strobe, address and modifier are synchronous to clk.
module vpx_strobe_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [5:0]        am,
    output logic [ADDR_W-1:0] addr_q,
    output logic [5:0]        am_q,
    output logic              pend
);
    logic as_q;
    logic fall;

    // Strobe falling-edge detect
    always_comb fall = as_q & ~as_n;

    // Capture registers and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q   <= 1'b1;
            pend   <= 1'b0;
            addr_q <= '0;
            am_q   <= '0;
        end else begin
            as_q <= as_n;
            pend <= fall;
            if (fall) begin
                addr_q <= addr;
                am_q   <= am;
            end
        end
    end
endmodule

// File: rtl/vpx_xlate.sv
// Combinational decision: picks the table from AM[5:4], qualifies with
// AM[3] and enable, translates, and tests the master window.
// Assumes the 24-bit table is replicated over the upper index bits.
module vpx_xlate
    import vpx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [5:0]        am_q,
    input  logic [1:0]        code_ext,
    input  logic [1:0]        code_std,
    input  logic              slave_en,
    input  logic [EXT_W-1:0]  ext_addr,
    input  logic [ADDR_W-1:0] mst_base,
    input  logic [ADDR_W-1:0] mst_mask,
    output logic              hit,
    output logic              win_err,
    output logic [ADDR_W-1:0] xaddr
);
    localparam int LOW_W = ADDR_W - EXT_W;

    logic       sel_ext, sel_std;
    logic [1:0] code;

    // Table selection from the modifier space bits
    always_comb begin
        sel_ext = (am_q[5:4] == AM_SPACE_EXT);
        sel_std = (am_q[5:4] == AM_SPACE_STD);
        code    = sel_std ? code_std : code_ext;
    end

    // Hit qualification, translation and window compare
    always_comb begin
        hit     = slave_en & am_q[3] & (sel_ext | sel_std) & code_is_target(code);
        xaddr   = (code == PG_A24) ? {ext_addr, addr_q[LOW_W-1:0]} : addr_q;
        win_err = hit & ((xaddr & mst_mask) == mst_base);
    end
endmodule

// File: rtl/vme_slave_page_map.sv
// Top of the VMEbus slave page map: two page tables, strobe capture,
// translation and the held request / bus-error outcome.
// Assumes software keeps the 24-bit table replicated over index bits
// above the low two, so the upper address bits of 24-bit cycles are moot.
module vme_slave_page_map #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 10,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vme_as_n,
    input  logic [ADDR_W-1:0] vme_addr,
    input  logic [5:0]        vme_am,
    input  logic              slave_en,
    input  logic [EXT_W-1:0]  ext_addr,
    input  logic [ADDR_W-1:0] mst_base,
    input  logic [ADDR_W-1:0] mst_mask,
    input  logic              map_wr_en,
    input  logic              map_wr_sel,
    input  logic [PAGE_W-1:0] map_wr_idx,
    input  logic [1:0]        map_wr_code,
    input  logic              map_rd_sel,
    input  logic [PAGE_W-1:0] map_rd_idx,
    output logic [1:0]        map_rd_code,
    input  logic              arb_ack,
    output logic              arb_req,
    output logic              bus_err,
    output logic [ADDR_W-1:0] local_addr
);
    localparam int NUM_TBL = 2;

    logic [ADDR_W-1:0] addr_q;
    logic [5:0]        am_q;
    logic              pend;
    logic [1:0]        lk_code [NUM_TBL];
    logic [1:0]        rd_code [NUM_TBL];
    logic              hit, win_err;
    logic [ADDR_W-1:0] xaddr;
    logic [PAGE_W-1:0] page_idx;

    // Page index from the top address bits
    always_comb page_idx = addr_q[ADDR_W-1 -: PAGE_W];

    vpx_strobe_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .as_n(vme_as_n), .addr(vme_addr),
        .am(vme_am), .addr_q(addr_q), .am_q(am_q), .pend(pend)
    );

    // Table 0 serves extended cycles, table 1 standard cycles
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        vpx_map_table #(.PAGE_W(PAGE_W)) u_tbl (
            .clk(clk), .rst_n(rst_n),
            .wr_en(map_wr_en && (map_wr_sel == 1'(g))),
            .wr_idx(map_wr_idx), .wr_code(map_wr_code),
            .lk_idx(page_idx), .lk_code(lk_code[g]),
            .rd_idx(map_rd_idx), .rd_code(rd_code[g])
        );
    end

    vpx_xlate #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_xl (
        .addr_q(addr_q), .am_q(am_q), .code_ext(lk_code[0]),
        .code_std(lk_code[1]), .slave_en(slave_en), .ext_addr(ext_addr),
        .mst_base(mst_base), .mst_mask(mst_mask), .hit(hit),
        .win_err(win_err), .xaddr(xaddr)
    );

    // Registered software read-back
    always_ff @(posedge clk) begin
        if (!rst_n) map_rd_code <= 2'b00;
        else        map_rd_code <= rd_code[map_rd_sel];
    end

    // Outcome register: set one edge after capture, held until ack or release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_req    <= 1'b0;
            bus_err    <= 1'b0;
            local_addr <= '0;
        end else if (vme_as_n || arb_ack) begin
            arb_req <= 1'b0;
            bus_err <= 1'b0;
        end else if (pend && hit) begin
            local_addr <= xaddr;
            arb_req    <= ~win_err;
            bus_err    <= win_err;
        end
    end

    assert_req_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_req && bus_err));

    assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_as_n || arb_ack) |=> (!arb_req && !bus_err));

    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arb_req) || $rose(bus_err)) |-> $past(slave_en));

    assert_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arb_req) || $rose(bus_err)) |-> $past(am_q[3]));

    assert_rdback_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr_en && map_rd_sel == map_wr_sel && map_rd_idx == map_wr_idx)
        ##1 (!map_wr_en && $stable(map_rd_idx) && $stable(map_rd_sel))
        |=> (map_rd_code == $past(map_wr_code, 2)));
endmodule

// File: tb/vme_slave_page_map_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module vme_slave_page_map_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vme_as_n = 1'b1;
    logic [31:0] vme_addr = '0;
    logic [5:0]  vme_am = '0;
    logic        slave_en = 1'b0;
    logic [7:0]  ext_addr = 8'h00;
    logic [31:0] mst_base = 32'h1;
    logic [31:0] mst_mask = 32'h0;
    logic        map_wr_en = 1'b0;
    logic        map_wr_sel = 1'b0;
    logic [9:0]  map_wr_idx = '0;
    logic [1:0]  map_wr_code = '0;
    logic        map_rd_sel = 1'b0;
    logic [9:0]  map_rd_idx = '0;
    logic [1:0]  map_rd_code;
    logic        arb_ack = 1'b0;
    logic        arb_req, bus_err;
    logic [31:0] local_addr;

    int checks = 0;
    int failures = 0;
    string tag = "R1";
    logic [31:0] seen_la;
    logic        seen_req, seen_err;

    always #2 clk = ~clk;

    vme_slave_page_map dut_i (
        .clk(clk), .rst_n(rst_n), .vme_as_n(vme_as_n), .vme_addr(vme_addr),
        .vme_am(vme_am), .slave_en(slave_en), .ext_addr(ext_addr),
        .mst_base(mst_base), .mst_mask(mst_mask), .map_wr_en(map_wr_en),
        .map_wr_sel(map_wr_sel), .map_wr_idx(map_wr_idx), .map_wr_code(map_wr_code),
        .map_rd_sel(map_rd_sel), .map_rd_idx(map_rd_idx), .map_rd_code(map_rd_code),
        .arb_ack(arb_ack), .arb_req(arb_req), .bus_err(bus_err), .local_addr(local_addr)
    );

    // Reference model state
    int          m_tbl [2][1024];
    bit          m_as_q, m_pend, m_req, m_err;
    bit [31:0]   m_addr, m_la;
    bit [5:0]    m_am;
    int          m_rd;

    always @(posedge clk) begin
        int code;
        bit space_ok, target;
        bit [31:0] xa;
        if (!rst_n) begin
            foreach (m_tbl[t, i]) m_tbl[t][i] = 0;
            m_as_q = 1; m_pend = 0; m_req = 0; m_err = 0;
            m_addr = 0; m_la = 0; m_am = 0; m_rd = 0;
        end else begin
            m_rd = m_tbl[map_rd_sel][map_rd_idx];
            space_ok = (m_am[5:4] == 2'b00) || (m_am[5:4] == 2'b11);
            code = m_tbl[(m_am[5:4] == 2'b11) ? 1 : 0][m_addr[31:22]];
            target = slave_en && m_am[3] && space_ok && (code == 1 || code == 2);
            xa = (code == 2) ? {ext_addr, m_addr[23:0]} : m_addr;
            if (vme_as_n || arb_ack) begin
                m_req = 0; m_err = 0;
            end else if (m_pend && target) begin
                m_la = xa;
                if ((xa & mst_mask) == mst_base) m_err = 1;
                else m_req = 1;
            end
            m_pend = m_as_q && !vme_as_n;
            if (m_pend) begin m_addr = vme_addr; m_am = vme_am; end
            m_as_q = vme_as_n;
            if (map_wr_en) m_tbl[map_wr_sel][map_wr_idx] = map_wr_code;
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (arb_req !== m_req || bus_err !== m_err || local_addr !== m_la ||
                map_rd_code !== 2'(m_rd)) begin
                failures++;
                $display("FAIL %s req/err/la/rd act=%0b/%0b/%h/%0d exp=%0b/%0b/%h/%0d",
                         tag, arb_req, bus_err, local_addr, map_rd_code,
                         m_req, m_err, m_la, m_rd);
            end
            if (arb_req || bus_err) begin
                seen_la = local_addr; seen_req = arb_req; seen_err = bus_err;
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit sel, int idx, int code);
        @(negedge clk);
        map_wr_en = 1; map_wr_sel = sel; map_wr_idx = 10'(idx); map_wr_code = 2'(code);
        @(negedge clk);
        map_wr_en = 0;
    endtask

    // One slave cycle; ack_at < 0 means release without acknowledge
    task automatic vcycle(logic [31:0] a, logic [5:0] am, int hold, int ack_at);
        seen_la = 'x; seen_req = 0; seen_err = 0;
        @(negedge clk);
        vme_addr = a; vme_am = am; vme_as_n = 0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            arb_ack = (k == ack_at);
        end
        @(negedge clk);
        arb_ack = 0; vme_as_n = 1;
        tick(2);
    endtask

    task automatic expect_hit(string t, bit req, bit err, logic [31:0] la);
        checks++;
        if (seen_req !== req || seen_err !== err || (req|err) && seen_la !== la) begin
            failures++;
            $display("FAIL %s act=%0b/%0b/%h exp=%0b/%0b/%h", t,
                     seen_req, seen_err, seen_la, req, err, la);
        end
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        failures++;
        $display("FAIL R9 watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tag = "R1";
        for (int i = 0; i < 4; i++) begin
            map_rd_sel = 1'(i & 1); map_rd_idx = 10'(i * 257); tick();
        end
        checks++;
        if (arb_req !== 0 || bus_err !== 0 || local_addr !== 0 || map_rd_code !== 0) begin
            failures++;
            $display("FAIL R1 reset act=%0b/%0b/%h/%0d exp=0/0/0/0",
                     arb_req, bus_err, local_addr, map_rd_code);
        end
        slave_en = 1; ext_addr = 8'h5A;

        tag = "R2";
        wr(0, 3, 1); wr(0, 4, 3); wr(0, 5, 0); wr(0, 6, 2); wr(1, 9, 2);
        map_rd_sel = 0; map_rd_idx = 3; tick(2);
        map_rd_idx = 4; tick(2);
        map_rd_sel = 1; map_rd_idx = 9; tick(2);
        map_rd_sel = 0; map_rd_idx = 6; tick(2);

        tag = "R4";
        vcycle(32'h00C1_2344, 6'h0D, 4, 2);
        expect_hit("R4 pass-through", 1, 0, 32'h00C1_2344);
        vcycle(32'h00FF_FFFC, 6'h09, 3, -1);
        expect_hit("R4 page end", 1, 0, 32'h00FF_FFFC);

        tag = "R5";
        vcycle(32'h0180_0010, 6'h0E, 3, 1);
        expect_hit("R5 ext page in 32-bit table", 1, 0, 32'h5A80_0010);

        tag = "R6";
        vcycle(32'h0100_0000, 6'h0D, 3, -1);
        expect_hit("R6 reserved", 0, 0, 0);
        vcycle(32'h0140_0000, 6'h0D, 3, -1);
        expect_hit("R6 unmapped", 0, 0, 0);

        tag = "R7";
        for (int i = 1; i < 1024; i += 4) wr(1, i, 2);
        vcycle(32'h0052_0010, 6'h3D, 3, 1);
        expect_hit("R7 upper=00", 1, 0, 32'h5A52_0010);
        vcycle(32'hAB52_0010, 6'h3D, 3, 1);
        expect_hit("R7 upper=AB", 1, 0, 32'h5A52_0010);
        vcycle(32'hFF9F_FFF0, 6'h39, 3, 1);
        expect_hit("R7 upper=FF unmapped low", 0, 0, 0);

        tag = "R3";
        vcycle(32'h00C0_0000, 6'h05, 3, -1);
        expect_hit("R3 AM3 clear", 0, 0, 0);
        vcycle(32'h00C0_0000, 6'h2D, 3, -1);
        expect_hit("R3 AM54=10", 0, 0, 0);
        vcycle(32'h00C0_0000, 6'h1D, 3, -1);
        expect_hit("R3 AM54=01", 0, 0, 0);
        vcycle(32'h0052_0000, 6'h0D, 3, -1);
        expect_hit("R3 ext table not std", 0, 0, 0);

        tag = "R8";
        slave_en = 0;
        vcycle(32'h00C1_0000, 6'h0D, 3, -1);
        expect_hit("R8 disabled", 0, 0, 0);
        slave_en = 1;

        tag = "R9";
        vcycle(32'h00C2_0000, 6'h0D, 5, 0);
        expect_hit("R9 ack at decision edge", 0, 0, 0);
        vcycle(32'h00C3_0000, 6'h0D, 6, -1);
        expect_hit("R9 held to release", 1, 0, 32'h00C3_0000);

        tag = "R10";
        mst_base = 32'h5A40_0000; mst_mask = 32'hFFC0_0000;
        vcycle(32'h0045_6780, 6'h3D, 4, 2);
        expect_hit("R10 window hit", 0, 1, 32'h5A45_6780);
        vcycle(32'h00C0_0040, 6'h0D, 3, -1);
        expect_hit("R10 outside window", 1, 0, 32'h00C0_0040);
        mst_base = 32'h1; mst_mask = 32'h0;

        tick(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule